// File: doc/BRIEF.md
# Interleaved Banked Memory Access Controller

This controller sits between a vector stream engine and a store of wide superwords, by default 512 bits each. The store is split into interleaved banks. The low-order bits of a superword address choose the bank. A bank stays busy for a fixed access time after each access, and that time is the same length as the bank count. Streams that walk through consecutive addresses therefore touch a different bank on every access and do not stall on the slow storage.

Four sources compete for the banks. A write stream delivers each superword as four 128-bit beats. Two read streams and a third read port, which carries instruction fetch, I/O and control-vector traffic, ask for whole superwords and receive them as four 128-bit beats. Sources that target different free banks are all granted in the same cycle. A source whose bank is still busy waits, and the other sources keep going. The bank storage is a behavioural array, and a per-bank down-counter models the access time.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset no read port shows valid data and the write port is ready to take a beat.
- R2: The bank of an access is the low log2(NBANK) bits of its superword address. Requests from different sources to distinct free banks are all granted in the same cycle.
- R3: A grant makes its bank busy for BANK_LAT cycles. A later request to that bank is granted at the clock edge exactly BANK_LAT cycles after the earlier grant, and not before.
- R4: A source that waits on a busy bank does not hold up a source whose bank is free. That source is granted while the other one waits.
- R5: When several sources want the same free bank in one cycle, the grant follows a fixed order: the write source first, then read port 0, then read port 1, then the misc port.
- R6: A read returns its superword on its own port. The first beat is visible BANK_LAT cycles after the granting edge, and the beats follow on consecutive cycles, least significant 128 bits first. The beat index goes 0, 1, 2, 3, and the tag reads 1 for read port 0, 2 for read port 1 and 3 for the misc port.
- R7: A write takes four beats, least significant quarter first, with the address given alongside beat 0. A later read returns the written word. While an assembled write waits for its bank, the write port does not accept beats.
- R8: After a grant, a read port is not granted again for BEATS-1 cycles, so back-to-back requests are granted four cycles apart. Their data come back in request order as one gapless run of beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_beat_valid | input | 1 | Write beat offered |
| wr_beat_ready | output | 1 | Write beat accepted at this edge |
| wr_beat_addr | input | AW | Superword address, sampled with beat 0 |
| wr_beat_data | input | BUS_W | Write beat payload |
| rd_req_valid | input | 3 | Read request per port (0, 1, misc) |
| rd_req_addr | input | 3*AW | Read superword address per port |
| rd_req_ready | output | 3 | Read request granted at this edge |
| rd_valid | output | 3 | Return beat valid per port |
| rd_data | output | 3*BUS_W | Return beat payload per port |
| rd_beat | output | 3*2 | Beat index per port |
| rd_tag | output | 3*2 | Source tag per port |

## Verification
Every result is tied to a clock edge. A read grant shows up as ready during the cycle before the granting edge. The bench records how many cycles each request waited, and compares that count with 0, BANK_LAT-1, BANK_LAT, 2*BANK_LAT or BEATS-1, depending on which banks and sources it contends with. From the granting edge the bench counts BANK_LAT-1 edges and confirms that no data is out yet. After one more edge it checks four beats on four consecutive cycles, and it samples each at the falling edge. For the write port, ready is checked in the cycle after the fourth beat, while the bank is still held by an earlier read.

// File: rtl/imc_pkg.sv
package imc_pkg;
   localparam int NUM_SRC = 4;
   localparam int NUM_RD  = 3;
   // Source index doubles as arbitration rank (lower wins) and return tag.
   typedef enum logic [1:0] {
      SRC_WR   = 2'd0,
      SRC_RD0  = 2'd1,
      SRC_RD1  = 2'd2,
      SRC_MISC = 2'd3
   } src_e;
endpackage

// File: rtl/imc_bank_tracker.sv
module imc_bank_tracker #(
   parameter int NBANK    = 32,
   parameter int BANK_LAT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBANK-1:0] claim,
   output logic [NBANK-1:0] free
);
   localparam int CW = $clog2(BANK_LAT + 1);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [CW-1:0] left;
      always_ff @(posedge clk) begin
         if (!rst_n)          left <= '0;
         else if (claim[b])   left <= CW'(BANK_LAT - 1);
         else if (left != '0) left <= left - 1'b1;
      end
      assign free[b] = (left == '0);
   end
endmodule

// File: rtl/imc_port_arbiter.sv
module imc_port_arbiter #(
   parameter int NSRC  = 4,
   parameter int NBANK = 32
) (
   input  logic [NSRC-1:0]                 want,
   input  logic [NSRC*$clog2(NBANK)-1:0]   bank,
   input  logic [NBANK-1:0]                bank_free,
   output logic [NSRC-1:0]                 grant,
   output logic [NBANK-1:0]                claim
);
   localparam int BB = $clog2(NBANK);

   logic [NBANK-1:0] taken;

   always_comb begin
      taken = '0;
      grant = '0;
      for (int p = 0; p < NSRC; p++) begin
         if (want[p] && bank_free[bank[p*BB +: BB]] && !taken[bank[p*BB +: BB]]) begin
            grant[p]                = 1'b1;
            taken[bank[p*BB +: BB]] = 1'b1;
         end
      end
      claim = taken;
   end
endmodule

// File: rtl/imc_write_assembler.sv
module imc_write_assembler #(
   parameter int AW     = 7,
   parameter int WORD_W = 512,
   parameter int BUS_W  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_valid,
   output logic              beat_ready,
   input  logic [AW-1:0]     beat_addr,
   input  logic [BUS_W-1:0]  beat_data,
   input  logic              granted,
   output logic              pend,
   output logic [AW-1:0]     pend_addr,
   output logic [WORD_W-1:0] pend_word
);
   localparam int BEATS = WORD_W / BUS_W;
   localparam int BW    = $clog2(BEATS);

   logic [BW-1:0] cnt;
   logic          take;

   assign beat_ready = !pend || granted;
   assign take       = beat_valid && beat_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (granted) pend <= 1'b0;
         if (take) begin
            if (cnt == BW'(BEATS - 1)) begin
               cnt  <= '0;
               pend <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         pend_word[cnt*BUS_W +: BUS_W] <= beat_data;
         if (cnt == '0) pend_addr <= beat_addr;
      end
   end
endmodule

// File: rtl/imc_read_return.sv
module imc_read_return #(
   parameter int BANK_LAT = 32,
   parameter int AW       = 7,
   parameter int WORD_W   = 512,
   parameter int BUS_W    = 128,
   parameter int TAG      = 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             issue,
   input  logic [AW-1:0]                    issue_addr,
   output logic [AW-1:0]                    look_addr,
   input  logic [WORD_W-1:0]                look_word,
   output logic                             out_valid,
   output logic [BUS_W-1:0]                 out_data,
   output logic [$clog2(WORD_W/BUS_W)-1:0]  out_beat,
   output logic [1:0]                       out_tag
);
   localparam int BEATS = WORD_W / BUS_W;
   localparam int BW    = $clog2(BEATS);

   logic [BANK_LAT-1:0] pv;
   logic [AW-1:0]       pa [BANK_LAT];
   logic [WORD_W-1:0]   sh;
   logic                land;

   // Access-time delay line: only valid and address travel; the word is
   // read from the array when the bank finishes.
   always_ff @(posedge clk) begin
      if (!rst_n) pv <= '0;
      else        pv <= {pv[BANK_LAT-2:0], issue};
   end

   always_ff @(posedge clk) begin
      pa[0] <= issue_addr;
      for (int k = 1; k < BANK_LAT; k++) pa[k] <= pa[k-1];
   end

   assign land      = pv[BANK_LAT-1];
   assign look_addr = pa[BANK_LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_beat  <= '0;
      end else if (land) begin
         out_valid <= 1'b1;
         out_beat  <= '0;
      end else if (out_valid) begin
         if (out_beat == BW'(BEATS - 1)) out_valid <= 1'b0;
         else                            out_beat  <= out_beat + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (land)           sh <= look_word;
      else if (out_valid) sh <= sh >> BUS_W;
   end

   assign out_data = sh[BUS_W-1:0];
   assign out_tag  = out_valid ? 2'(TAG) : 2'd0;
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
   import imc_pkg::*;
#(
   parameter int NBANK    = 32,
   parameter int BANK_LAT = 32,
   parameter int AW       = 7,
   parameter int WORD_W   = 512,
   parameter int BUS_W    = 128
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_beat_valid,
   output logic                               wr_beat_ready,
   input  logic [AW-1:0]                      wr_beat_addr,
   input  logic [BUS_W-1:0]                   wr_beat_data,
   input  logic [NUM_RD-1:0]                  rd_req_valid,
   input  logic [NUM_RD*AW-1:0]               rd_req_addr,
   output logic [NUM_RD-1:0]                  rd_req_ready,
   output logic [NUM_RD-1:0]                  rd_valid,
   output logic [NUM_RD*BUS_W-1:0]            rd_data,
   output logic [NUM_RD*$clog2(WORD_W/BUS_W)-1:0] rd_beat,
   output logic [NUM_RD*2-1:0]                rd_tag
);
   localparam int BEATS = WORD_W / BUS_W;
   localparam int BW    = $clog2(BEATS);
   localparam int BB    = $clog2(NBANK);
   localparam int DEPTH = 1 << AW;

   if ((NBANK < 2) || ((1 << BB) != NBANK)) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end
   if (AW <= BB) begin : g_bad_aw
      $error("AW must exceed the bank select width");
   end
   if ((WORD_W % BUS_W) != 0 || BEATS < 2 || ((1 << BW) != BEATS)) begin : g_bad_beats
      $error("WORD_W/BUS_W must be a power of two of at least 2");
   end
   if (BANK_LAT < 2) begin : g_bad_lat
      $error("BANK_LAT must be at least 2");
   end

   logic [NUM_SRC-1:0]    src_want, src_grant;
   logic [NUM_SRC*BB-1:0] src_bank;
   logic [NBANK-1:0]      bank_free, bank_claim;
   logic                  wp_pend;
   logic [AW-1:0]         wp_addr;
   logic [WORD_W-1:0]     wp_word;
   logic [WORD_W-1:0]     mem [DEPTH];
   logic [AW-1:0]         look_addr [NUM_RD];

   imc_write_assembler #(.AW(AW), .WORD_W(WORD_W), .BUS_W(BUS_W)) u_wasm (
      .clk(clk), .rst_n(rst_n),
      .beat_valid(wr_beat_valid), .beat_ready(wr_beat_ready),
      .beat_addr(wr_beat_addr), .beat_data(wr_beat_data),
      .granted(src_grant[SRC_WR]),
      .pend(wp_pend), .pend_addr(wp_addr), .pend_word(wp_word)
   );

   assign src_want[SRC_WR]             = wp_pend;
   assign src_bank[SRC_WR*BB +: BB]    = wp_addr[BB-1:0];

   for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
      logic [BW-1:0] gap;
      always_ff @(posedge clk) begin
         if (!rst_n)              gap <= '0;
         else if (src_grant[i+1]) gap <= BW'(BEATS - 1);
         else if (gap != '0)      gap <= gap - 1'b1;
      end

      assign src_want[i+1]          = rd_req_valid[i] && (gap == '0);
      assign src_bank[(i+1)*BB +: BB] = rd_req_addr[i*AW +: BB];
      assign rd_req_ready[i]        = src_grant[i+1];

      imc_read_return #(
         .BANK_LAT(BANK_LAT), .AW(AW), .WORD_W(WORD_W), .BUS_W(BUS_W), .TAG(i + 1)
      ) u_ret (
         .clk(clk), .rst_n(rst_n),
         .issue(src_grant[i+1]), .issue_addr(rd_req_addr[i*AW +: AW]),
         .look_addr(look_addr[i]), .look_word(mem[look_addr[i]]),
         .out_valid(rd_valid[i]), .out_data(rd_data[i*BUS_W +: BUS_W]),
         .out_beat(rd_beat[i*BW +: BW]), .out_tag(rd_tag[i*2 +: 2])
      );
   end

   imc_port_arbiter #(.NSRC(NUM_SRC), .NBANK(NBANK)) u_arb (
      .want(src_want), .bank(src_bank), .bank_free(bank_free),
      .grant(src_grant), .claim(bank_claim)
   );

   imc_bank_tracker #(.NBANK(NBANK), .BANK_LAT(BANK_LAT)) u_busy (
      .clk(clk), .rst_n(rst_n), .claim(bank_claim), .free(bank_free)
   );

   always_ff @(posedge clk) begin
      if (src_grant[SRC_WR]) mem[wp_addr] <= wp_word;
   end
endmodule

// File: rtl/imc_checker.sv
module imc_checker
   import imc_pkg::*;
#(
   parameter int NBANK    = 32,
   parameter int BANK_LAT = 32,
   parameter int BEATS    = 4
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_SRC-1:0]                grant,
   input logic [NUM_SRC*$clog2(NBANK)-1:0]  bank,
   input logic [NUM_RD-1:0]                 rd_req_ready,
   input logic [NUM_RD-1:0]                 rd_valid,
   input logic [NUM_RD*$clog2(BEATS)-1:0]   rd_beat,
   input logic                              wr_pend,
   input logic                              wr_beat_ready
);
   localparam int BB = $clog2(NBANK);
   localparam int BW = $clog2(BEATS);

   for (genvar p = 0; p < NUM_SRC; p++) begin : g_p
      for (genvar q = 0; q < NUM_SRC; q++) begin : g_q
         if (p < q) begin : g_pair
            // R5: one winner per bank in any cycle
            a_r5_bank_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
               (grant[p] && grant[q]) |-> (bank[p*BB +: BB] != bank[q*BB +: BB]));
         end
         if (BANK_LAT > 1) begin : g_hold
            // R3: a bank just granted is not granted again on the next edge
            a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
               grant[p] |=> !(grant[q] && (bank[q*BB +: BB] == $past(bank[p*BB +: BB]))));
         end
      end
   end

   for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
      // R8: no back-to-back grants on one read port
      a_r8_port_gap: assert property (@(posedge clk) disable iff (!rst_n)
         rd_req_ready[i] |=> !rd_req_ready[i]);
      // R6: beats of a superword are contiguous and counted upward
      a_r6_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_valid[i] && (rd_beat[i*BW +: BW] != BW'(BEATS - 1)))
         |=> (rd_valid[i] && (rd_beat[i*BW +: BW] == $past(rd_beat[i*BW +: BW]) + 1'b1)));
   end

   // R7: an unplaced write word blocks further beats
   a_r7_beats_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && !grant[0]) |-> !wr_beat_ready);
endmodule

bind ilv_mem_ctrl imc_checker #(
   .NBANK(NBANK), .BANK_LAT(BANK_LAT), .BEATS(WORD_W / BUS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .grant(src_grant), .bank(src_bank),
   .rd_req_ready(rd_req_ready), .rd_valid(rd_valid), .rd_beat(rd_beat),
   .wr_pend(wp_pend), .wr_beat_ready(wr_beat_ready)
);

// File: tb/ilv_mem_ctrl_test.sv
module ilv_mem_ctrl_test;
   localparam int L  = 32;
   localparam int AW = 7;
   localparam int BW = 128;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wr_beat_valid, wr_beat_ready;
   logic [AW-1:0]   wr_beat_addr;
   logic [BW-1:0]   wr_beat_data;
   logic [2:0]      rd_req_valid, rd_req_ready, rd_valid;
   logic [3*AW-1:0] rd_req_addr;
   logic [3*BW-1:0] rd_data;
   logic [5:0]      rd_beat, rd_tag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   ilv_mem_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .wr_beat_valid(wr_beat_valid), .wr_beat_ready(wr_beat_ready),
      .wr_beat_addr(wr_beat_addr), .wr_beat_data(wr_beat_data),
      .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_beat(rd_beat), .rd_tag(rd_tag)
   );

   function automatic logic [511:0] mk(input int a, input int salt);
      logic [511:0] w;
      for (int l = 0; l < 16; l++) w[l*32 +: 32] = {8'(salt), 8'(a), 8'(l), 8'h5A};
      return w;
   endfunction

   task automatic chk(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic wr_word(input int a, input logic [511:0] w);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         wr_beat_valid = 1'b1;
         wr_beat_addr  = AW'(a);
         wr_beat_data  = w[k*BW +: BW];
         #1;
         while (!wr_beat_ready) begin @(negedge clk); #1; end
         @(posedge clk);
         wr_beat_valid <= 1'b0;
      end
   endtask

   // Returns at the granting edge.
   task automatic issue(input int p, input int a, input int exp_wait, input string req);
      int waited = 0;
      @(negedge clk);
      rd_req_valid[p] = 1'b1;
      rd_req_addr[p*AW +: AW] = AW'(a);
      #1;
      while (!rd_req_ready[p]) begin waited++; @(negedge clk); #1; end
      if (exp_wait >= 0)
         chk(waited == exp_wait, $sformatf("%s port %0d addr %0d: waited %0d cycles, expected %0d",
                                           req, p, a, waited, exp_wait));
      @(posedge clk);
      rd_req_valid[p] <= 1'b0;
   endtask

   task automatic check_beats(input int p, input logic [511:0] w);
      for (int k = 0; k < 4; k++) begin
         if (k > 0) begin @(posedge clk); @(negedge clk); end
         chk(rd_valid[p] && rd_data[p*BW +: BW] == w[k*BW +: BW] &&
             rd_beat[p*2 +: 2] == 2'(k) && rd_tag[p*2 +: 2] == 2'(p + 1),
             $sformatf("R6 port %0d beat %0d: got v=%0b idx=%0d tag=%0d data=%h, expected v=1 idx=%0d tag=%0d data=%h",
                       p, k, rd_valid[p], rd_beat[p*2 +: 2], rd_tag[p*2 +: 2], rd_data[p*BW +: BW],
                       k, p + 1, w[k*BW +: BW]));
      end
   endtask

   // Called at the granting edge.
   task automatic check_return(input int p, input logic [511:0] w);
      repeat (L - 1) @(posedge clk);
      @(negedge clk);
      chk(!rd_valid[p], $sformatf("R6 port %0d early data: got valid=%0b, expected 0", p, rd_valid[p]));
      @(posedge clk);
      @(negedge clk);
      check_beats(p, w);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      wr_beat_valid = 1'b0; wr_beat_addr = '0; wr_beat_data = '0;
      rd_req_valid = '0; rd_req_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_valid == 3'b000, $sformatf("R1 rd_valid after reset: got %b, expected 000", rd_valid));
      chk(wr_beat_ready, $sformatf("R1 wr_beat_ready after reset: got %0b, expected 1", wr_beat_ready));
   endtask

   task automatic t_setup();
      int addrs[11] = '{1, 2, 3, 9, 10, 11, 12, 13, 7, 39, 71};
      foreach (addrs[i]) wr_word(addrs[i], mk(addrs[i], 0));
      repeat (2 * L) @(posedge clk);
   endtask

   // R7 write then R5 write beats read 0 on one bank, R3 wait is L.
   task automatic t_write_read();
      wr_word(5, mk(5, 1));
      issue(0, 5, L, "R3/R5 write before read0");
      check_return(0, mk(5, 1));
   endtask

   // R2: three distinct banks granted together.
   task automatic t_parallel();
      fork
         begin issue(0, 1, 0, "R2"); check_return(0, mk(1, 0)); end
         begin issue(1, 2, 0, "R2"); check_return(1, mk(2, 0)); end
         begin issue(2, 3, 0, "R2"); check_return(2, mk(3, 0)); end
      join
   endtask

   // R5/R3: three reads on bank 7.
   task automatic t_priority();
      fork
         begin issue(0, 7,  0,     "R5"); check_return(0, mk(7, 0));  end
         begin issue(1, 39, L,     "R5"); check_return(1, mk(39, 0)); end
         begin issue(2, 71, 2 * L, "R5"); check_return(2, mk(71, 0)); end
      join
   endtask

   // R4: misc on a free bank proceeds while read 1 waits on bank 9.
   task automatic t_stall_local();
      fork
         begin issue(0, 9,  0, "R4"); check_return(0, mk(9, 0));  end
         begin issue(1, 9,  L, "R4"); check_return(1, mk(9, 0));  end
         begin issue(2, 10, 0, "R4"); check_return(2, mk(10, 0)); end
      join
   endtask

   // R8: back-to-back on one port, four cycles apart, ordered gapless return.
   task automatic t_spacing();
      issue(0, 11, 0, "R8");
      fork
         begin
            check_return(0, mk(11, 0));
            @(posedge clk); @(negedge clk);
            check_beats(0, mk(12, 0));
         end
         issue(0, 12, 3, "R8");
      join
   endtask

   // R7: beats refused while the assembled word waits on a busy bank.
   task automatic t_write_hold();
      fork
         begin issue(0, 13, 0, "R7"); check_return(0, mk(13, 0)); end
         begin
            wr_word(45, mk(45, 7));
            @(negedge clk);
            chk(!wr_beat_ready, $sformatf("R7 wr_beat_ready while pending: got %0b, expected 0", wr_beat_ready));
         end
      join
      issue(1, 45, -1, "R7");
      check_return(1, mk(45, 7));
   endtask

   initial begin
      t_reset();
      t_setup();
      t_write_read();
      t_parallel();
      t_priority();
      t_stall_local();
      t_spacing();
      t_write_hold();
      repeat (4) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule